// File: doc/BRIEF.md
# Gray-Code Time-Stamp Converter Back-End

This block is the digital half of a single-slope converter. A start strobe clears a Gray-coded time counter and starts it at the moment the analog ramp begins. When the comparator reports that the ramp has crossed its reference, the running count is frozen as the sample's time stamp. The counter steps once per half-period of the fast converter clock. Here it is modelled as one code per cycle of a doubled counting clock, `clk`. Because it is Gray-coded, exactly one bit moves per step, so a capture that is asynchronous to the count can never pick up a torn code.

The comparator input is asynchronous and passes through a synchroniser. Only its first rising edge inside a conversion counts. A conversion whose comparator never trips saturates at full scale and carries an overflow flag. Two sample-hold slots take turns: every accepted strobe swaps which slot is converted, and each result names its slot. The result leaves on a valid/ready port and is also given in binary. A result that is held and not taken stays stable. No new conversion starts until the consumer takes the result, which is how back-pressure reaches the converter. With ready held high, the valid signal is a single-cycle pulse.

Top module: `tsadc_backend`

## Requirements
- R1: After reset, `res_valid_o`, `busy_o` and `res_ovf_o` are 0 and `conv_slot_o` is 1.
- R2: A strobe sampled while idle, and while no result is pending (or the pending one is taken in the same cycle), starts a conversion. `busy_o` is high from the next cycle, and `conv_slot_o` toggles at that edge.
- R3: If no trip is seen by the time the count reaches the top binary value 255, the counter halts there. The result is then posted with binary 255, Gray code 8'h80 and `res_ovf_o`=1, 256 cycles after the start edge.
- R4: If the comparator input rises j cycles after the start edge, with j ≤ 253, the result has binary value j+2 (a fixed latency of the two synchroniser stages). It appears j+3 cycles after the start edge with `res_ovf_o`=0.
- R5: While converting, the internal counter changes by at most one bit per cycle.
- R6: Only the first comparator rise in a conversion makes a result. Comparator activity while idle makes no result and starts nothing.
- R7: A strobe during a conversion is ignored. It does not restart the count and does not toggle `conv_slot_o`.
- R8: While `res_valid_o` is high and `res_ready_i` is low, the result fields hold steady and strobes are ignored.
- R9: `res_gray_o` equals `res_bin_o ^ (res_bin_o >> 1)`. `res_slot_o` equals the `conv_slot_o` value of the conversion that produced the result.
- R10: A result taken with `res_ready_i` high is followed by `res_valid_o` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (one code per cycle) |
| rst_n | input | 1 | Active-low reset |
| strobe_i | input | 1 | Ramp start strobe |
| cmp_trip_i | input | 1 | Asynchronous comparator output, high once the ramp has crossed |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_valid_o | output | 1 | Result is present |
| res_gray_o | output | CODE_W | Captured time stamp, Gray code |
| res_bin_o | output | CODE_W | Captured time stamp, binary |
| res_ovf_o | output | 1 | Result saturated at full scale |
| res_slot_o | output | 1 | Sample-hold slot the result belongs to |
| conv_slot_o | output | 1 | Slot currently being converted (the other one is filling) |
| busy_o | output | 1 | Conversion in progress |

## Verification
The hardest case to reach from the ports is the edge of full scale. A trip detected in the very cycle the count reaches 255 must give a normal result. A trip one cycle later must give the saturated, flagged result. The stimulus gets there by placing the comparator rise at exact cycle offsets after the start edge (253, 254 and never), with the synchroniser latency counted in. Back-pressure is reached by holding ready low across a finished conversion and firing a strobe into the pending result.

// File: rtl/tsadc_pkg.sv
package tsadc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tsadc_state_e;
endpackage

// File: rtl/tsadc_sync.sv
// Multi-stage synchroniser for an asynchronous level (STAGES >= 2).
module tsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tsadc_gray2bin.sv
// Gray to binary: each binary bit is the XOR of all Gray bits at and above it.
module tsadc_gray2bin #(
  parameter int W = 8
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/tsadc_gray_ctr.sv
// Gray counter held directly in Gray form; clears on clr_i and halts at full scale.
module tsadc_gray_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] gray_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] GMAX = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] g_q;
  logic [W-1:0] bin_w;
  logic [W-1:0] inc_w;
  logic [W-1:0] g_next;

  tsadc_gray2bin #(.W(W)) u_dec (
    .gray_i (g_q),
    .bin_o  (bin_w)
  );

  always_comb begin
    inc_w  = bin_w + 1'b1;
    g_next = inc_w ^ (inc_w >> 1);
  end

  assign at_max_o = (g_q == GMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   g_q <= '0;
    else if (clr_i)               g_q <= '0;
    else if (en_i && !at_max_o)   g_q <= g_next;
  end

  assign gray_o = g_q;
endmodule

// File: rtl/tsadc_backend.sv
// Single-slope converter back-end: Gray time counter, trip capture,
// ping-pong slot tracking and a valid/ready result port.
module tsadc_backend
  import tsadc_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              cmp_trip_i,
  input  logic              res_ready_i,
  output logic              res_valid_o,
  output logic [CODE_W-1:0] res_gray_o,
  output logic [CODE_W-1:0] res_bin_o,
  output logic              res_ovf_o,
  output logic              res_slot_o,
  output logic              conv_slot_o,
  output logic              busy_o
);
  tsadc_state_e      state_q;
  logic              cmp_s;
  logic              cmp_prev_q;
  logic [CODE_W-1:0] cnt_gray;
  logic              cnt_max;
  logic              start_w;
  logic              trip_w;
  logic              sat_w;
  logic              done_w;

  tsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_trip_i),
    .q_o   (cmp_s)
  );

  // A start needs an idle converter and a free (or just-taken) result slot.
  assign start_w = strobe_i && (state_q == ST_IDLE) && (!res_valid_o || res_ready_i);
  // First synchronised rise while running.
  assign trip_w  = (state_q == ST_RUN) && cmp_s && !cmp_prev_q;
  // Full scale reached without a trip.
  assign sat_w   = (state_q == ST_RUN) && cnt_max && !trip_w;
  assign done_w  = trip_w || sat_w;

  tsadc_gray_ctr #(.W(CODE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (start_w),
    .en_i     ((state_q == ST_RUN) && !trip_w),
    .gray_o   (cnt_gray),
    .at_max_o (cnt_max)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      conv_slot_o <= 1'b1;
      cmp_prev_q  <= 1'b0;
    end else begin
      cmp_prev_q <= cmp_s;
      if (start_w) begin
        state_q     <= ST_RUN;
        conv_slot_o <= ~conv_slot_o;
      end else if (done_w) begin
        state_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_gray_o  <= '0;
      res_ovf_o   <= 1'b0;
      res_slot_o  <= 1'b0;
    end else if (done_w) begin
      res_valid_o <= 1'b1;
      res_gray_o  <= cnt_gray;
      res_ovf_o   <= sat_w;
      res_slot_o  <= conv_slot_o;
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end

  tsadc_gray2bin #(.W(CODE_W)) u_out_dec (
    .gray_i (res_gray_o),
    .bin_o  (res_bin_o)
  );

  assign busy_o = (state_q == ST_RUN);
endmodule

// File: rtl/tsadc_backend_chk.sv
module tsadc_backend_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_i,
  input logic              res_ready_i,
  input logic              res_valid_o,
  input logic [CODE_W-1:0] res_gray_o,
  input logic [CODE_W-1:0] res_bin_o,
  input logic              res_ovf_o,
  input logic              res_slot_o,
  input logic              conv_slot_o,
  input logic              busy_o,
  input logic [CODE_W-1:0] cnt_gray
);
  localparam logic [CODE_W-1:0] GMAX = {1'b1, {(CODE_W-1){1'b0}}};

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && strobe_i && (!res_valid_o || res_ready_i) |=>
      busy_o && (conv_slot_o != $past(conv_slot_o)));

  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (cnt_gray == GMAX) |=> !busy_o && res_valid_o);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_ovf_o |-> res_gray_o == GMAX);

  p_onebit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $countones(cnt_gray ^ $past(cnt_gray)) <= 1);

  p_from_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> $past(busy_o) && !busy_o);

  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && strobe_i |=> $stable(conv_slot_o));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_gray_o)
      && $stable(res_ovf_o) && $stable(res_slot_o) && !busy_o);

  p_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> ((res_bin_o ^ (res_bin_o >> 1)) == res_gray_o));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_ready_i |=> !res_valid_o);
endmodule

bind tsadc_backend tsadc_backend_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe_i    (strobe_i),
  .res_ready_i (res_ready_i),
  .res_valid_o (res_valid_o),
  .res_gray_o  (res_gray_o),
  .res_bin_o   (res_bin_o),
  .res_ovf_o   (res_ovf_o),
  .res_slot_o  (res_slot_o),
  .conv_slot_o (conv_slot_o),
  .busy_o      (busy_o),
  .cnt_gray    (cnt_gray)
);

// File: tb/tb_tsadc_backend.sv
module tb_tsadc_backend;
  localparam int W    = 8;
  localparam int SYNC = 2;
  localparam int TOP  = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic cmp = 1'b0;
  logic ready = 1'b1;
  logic res_valid, res_ovf, res_slot, conv_slot, busy;
  logic [W-1:0] res_gray, res_bin;

  int checks = 0;
  int errors = 0;
  logic exp_slot = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tsadc_backend #(.CODE_W(W), .SYNC_STAGES(SYNC)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (strobe),
    .cmp_trip_i  (cmp),
    .res_ready_i (ready),
    .res_valid_o (res_valid),
    .res_gray_o  (res_gray),
    .res_bin_o   (res_bin),
    .res_ovf_o   (res_ovf),
    .res_slot_o  (res_slot),
    .conv_slot_o (conv_slot),
    .busy_o      (busy)
  );

  function automatic int to_gray(int b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // j: cycles after the start edge at which the comparator rises (large = never).
  task automatic run_conv(int j, bit restrobe, bit bp);
    int idx;
    int e_idx, e_bin;
    bit e_ovf;
    logic [W-1:0] held;
    ready = !bp;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    exp_slot = ~exp_slot;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(conv_slot == exp_slot, "R2 slot toggle", conv_slot, exp_slot);
    idx = 0;
    if (j == 0) cmp = 1'b1;
    while (!res_valid && idx < 400) begin
      @(negedge clk);
      idx++;
      if (idx == j) cmp = 1'b1;
      strobe = restrobe && (idx == 3);
    end
    strobe = 1'b0;
    if (j <= TOP - SYNC) begin e_idx = j + SYNC + 1; e_bin = j + SYNC; e_ovf = 1'b0; end
    else begin e_idx = TOP + 1; e_bin = TOP; e_ovf = 1'b1; end
    chk(idx == e_idx, e_ovf ? "R3 saturation timing" : "R4 capture timing", idx, e_idx);
    chk(int'(res_bin) == e_bin, e_ovf ? "R3 saturated value" : "R4 captured value", res_bin, e_bin);
    chk(res_ovf == e_ovf, "R3 overflow flag", res_ovf, e_ovf);
    chk(int'(res_gray) == to_gray(e_bin), "R9 gray encoding", res_gray, to_gray(e_bin));
    chk(res_slot == exp_slot, "R9 result slot", res_slot, exp_slot);
    if (restrobe) chk(conv_slot == exp_slot, "R7 slot after mid strobe", conv_slot, exp_slot);
    if (bp) begin
      held = res_gray;
      strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b1, "R8 valid held", res_valid, 1);
      chk(res_gray == held, "R8 data held", res_gray, held);
      chk(busy == 1'b0 && conv_slot == exp_slot, "R8 strobe ignored", busy, 0);
      ready = 1'b1;
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 valid one cycle", res_valid, 0);
    chk(busy == 1'b0, "R6 idle after result", busy, 0);
    cmp = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_toggle();
    cmp = 1'b1;
    repeat (2) @(negedge clk);
    cmp = 1'b0;
    @(negedge clk);
    cmp = 1'b1;
    repeat (5) @(negedge clk);
    chk(res_valid == 1'b0, "R6 idle trip no result", res_valid, 0);
    chk(busy == 1'b0, "R6 idle trip no start", busy, 0);
    cmp = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid reset", res_valid, 0);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(res_ovf == 1'b0, "R1 ovf reset", res_ovf, 0);
    chk(conv_slot == 1'b1, "R1 slot reset", conv_slot, 1);

    idle_toggle();
    run_conv(0, 1'b0, 1'b0);
    run_conv(1, 1'b0, 1'b0);
    idle_toggle();
    run_conv(TOP - SYNC, 1'b0, 1'b0);
    run_conv(TOP - SYNC + 1, 1'b0, 1'b0);
    run_conv(1000, 1'b0, 1'b0);
    run_conv(20, 1'b1, 1'b0);
    run_conv(7, 1'b0, 1'b1);
    run_conv(1000, 1'b0, 1'b1);

    for (int i = 0; i < 25; i++) begin
      int j;
      j = int'($urandom_range(0, 200));
      run_conv(j, ($urandom_range(0, 4) == 0), ($urandom_range(0, 3) == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule